// File: doc/BRIEF.md
# Event-Trigger Prescaler with Latched Status Flags

This block sits behind an event-selection stage and serves three trigger channels. Two channels start conversions and one raises interrupts. Each channel receives a single-cycle event strobe and counts those strobes. When the count reaches the channel's programmed period, the channel emits a one-cycle trigger pulse and its counter starts again from zero. A period of zero turns the channel off.

Every trigger pulse sets a sticky status flag. Software reads the flags as a 16-bit word and clears them through a separate write-one-to-clear input.

The two conversion channels keep pulsing while their flags are set. The interrupt channel is gated by its flag. While the flag is set, no new interrupt pulse leaves the block. At most one further interrupt is held as pending, and it is sent on the cycle after software clears the flag.

Top module: `evtrig_prescale`

## Requirements
- R1: After a synchronous reset, all counters read 0, the flag word reads 0 and no pulse is driven.
- R2: When a channel's period is nonzero and not below its count, each event strobe on that channel raises its count by one. Count fields in `cnt_o`: interrupt [3:0], conversion A [7:4], conversion B [11:8].
- R3: A channel whose period is 0 holds its count at 0 and never pulses, whatever events arrive.
- R4: The event that brings the count to the period value (1..15) causes a pulse one cycle after that event. In the same cycle the count reads 0. Pulse bits: interrupt bit 0, conversion A bit 1, conversion B bit 2.
- R5: A pulse on conversion A or B sets that channel's flag. Later period matches keep producing pulses while the flag stays set.
- R6: Flag word layout: bit 0 is the interrupt flag, bit 2 is conversion A and bit 3 is conversion B. All other bits read 0.
- R7: Writing 1 to a flag's bit position in `clr_i` clears that flag. If a set occurs in the same cycle as the clear, the set wins. Ones written in unused bit positions have no effect.
- R8: While the interrupt flag is set and not being cleared, no interrupt pulse is produced. One match is kept as pending, and any further matches are dropped.
- R9: A pending interrupt is pulsed in the cycle after the clear that removes the flag, and the flag is set again.
- R10: If a channel's period becomes lower than its count, the count returns to 0 on the next cycle and that cycle's event is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 3 | Event strobes: bit 0 interrupt, bit 1 conversion A, bit 2 conversion B |
| prd_i | input | 12 | Period selects, 4 bits per channel, same order as `cnt_o` |
| clr_i | input | 16 | Write-one-to-clear, laid out the same as the flag word |
| pulse_o | output | 3 | One-cycle trigger pulses, same order as `evt_i` |
| flag_word_o | output | 16 | Latched status flag word |
| cnt_o | output | 12 | Current event counts |

## Verification
The bench uses the default 4-bit counter width. With this width every period from 1 to 15 is within reach, including a period of 15 and a period of 1, where every event pulses. The random phase changes periods while counts are partway through. This covers the reset-on-lower-period path and a clear arriving in the same cycle as a set. The directed cases stack several interrupt matches on a set flag to show that only one is kept pending.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;
    localparam int NCH = 3;

    typedef enum int {
        CH_INT  = 0,
        CH_SOCA = 1,
        CH_SOCB = 2
    } chan_e;

    localparam int FLG_W      = 16;
    localparam int FLG_POS_INT  = 0;
    localparam int FLG_POS_SOCA = 2;
    localparam int FLG_POS_SOCB = 3;

    typedef struct packed {
        logic socb;
        logic soca;
        logic intr;
    } chan_bits_t;

    function automatic int flag_pos(input int ch);
        case (ch)
            CH_INT:  return FLG_POS_INT;
            CH_SOCA: return FLG_POS_SOCA;
            default: return FLG_POS_SOCB;
        endcase
    endfunction

    function automatic logic [FLG_W-1:0] pack_flags(input chan_bits_t f);
        logic [FLG_W-1:0] w;
        w = '0;
        w[FLG_POS_INT]  = f.intr;
        w[FLG_POS_SOCA] = f.soca;
        w[FLG_POS_SOCB] = f.socb;
        return w;
    endfunction
endpackage

// File: rtl/evtrig_counter.sv
module evtrig_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] next_ext;
    logic             off;

    assign off      = (prd == '0) || (cnt_q > prd);
    assign next_ext = {1'b0, cnt_q} + EXT_W'(1);
    assign match    = !off && evt && (next_ext == {1'b0, prd});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (off || match) begin
            cnt_q <= '0;
        end else if (evt) begin
            cnt_q <= next_ext[CNT_W-1:0];
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/evtrig_soc_latch.sv
module evtrig_soc_latch (
    input  logic clk,
    input  logic rst,
    input  logic match,
    input  logic clr,
    output logic pulse,
    output logic flag
);
    logic pulse_q, flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= match;
            flag_q  <= (flag_q && !clr) || match;
        end
    end

    assign pulse = pulse_q;
    assign flag  = flag_q;
endmodule

// File: rtl/evtrig_int_gate.sv
module evtrig_int_gate (
    input  logic clk,
    input  logic rst,
    input  logic match,
    input  logic clr,
    output logic pulse,
    output logic flag
);
    logic pulse_q, flag_q, pend_q;
    logic flag_eff, fire;

    assign flag_eff = flag_q && !clr;
    assign fire     = !flag_eff && (pend_q || match);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            pulse_q <= fire;
            flag_q  <= flag_eff || fire;
            pend_q  <= fire ? (pend_q && match) : (pend_q || match);
        end
    end

    assign pulse = pulse_q;
    assign flag  = flag_q;
endmodule

// File: rtl/evtrig_prescale.sv
module evtrig_prescale
    import evtrig_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       evt_i,
    input  logic [NCH*CNT_W-1:0] prd_i,
    input  logic [FLG_W-1:0]     clr_i,
    output logic [NCH-1:0]       pulse_o,
    output logic [FLG_W-1:0]     flag_word_o,
    output logic [NCH*CNT_W-1:0] cnt_o
);
    logic [NCH-1:0] match_w;
    logic [NCH-1:0] flag_w;
    chan_bits_t     flags_s;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        evtrig_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .evt   (evt_i[g]),
            .prd   (prd_i[g*CNT_W +: CNT_W]),
            .cnt   (cnt_o[g*CNT_W +: CNT_W]),
            .match (match_w[g])
        );

        if (g == CH_INT) begin : g_int
            evtrig_int_gate u_gate (
                .clk   (clk),
                .rst   (rst),
                .match (match_w[g]),
                .clr   (clr_i[flag_pos(g)]),
                .pulse (pulse_o[g]),
                .flag  (flag_w[g])
            );
        end else begin : g_soc
            evtrig_soc_latch u_latch (
                .clk   (clk),
                .rst   (rst),
                .match (match_w[g]),
                .clr   (clr_i[flag_pos(g)]),
                .pulse (pulse_o[g]),
                .flag  (flag_w[g])
            );
        end
    end

    assign flags_s.intr = flag_w[CH_INT];
    assign flags_s.soca = flag_w[CH_SOCA];
    assign flags_s.socb = flag_w[CH_SOCB];
    assign flag_word_o  = pack_flags(flags_s);
endmodule

// File: rtl/evtrig_checker.sv
module evtrig_checker #(
    parameter int CNT_W = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           evt_i,
    input logic [3*CNT_W-1:0]   prd_i,
    input logic [15:0]          clr_i,
    input logic [2:0]           pulse_o,
    input logic [15:0]          flag_word_o,
    input logic [3*CNT_W-1:0]   cnt_o
);
    logic [CNT_W-1:0] prd_a, cnt_a;
    assign prd_a = prd_i[CNT_W +: CNT_W];
    assign cnt_a = cnt_o[CNT_W +: CNT_W];

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_i[1] && prd_a != '0 && cnt_a < prd_a) |=>
        (cnt_a == $past(cnt_a) + CNT_W'(1) || cnt_a == '0));

    assert_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        (prd_a == '0) |=> (cnt_a == '0 && !pulse_o[1]));

    assert_pulse_zero_R4: assert property (@(posedge clk) disable iff (rst)
        pulse_o[1] |-> (cnt_a == '0));

    assert_soc_flag_R5: assert property (@(posedge clk) disable iff (rst)
        pulse_o[2] |-> flag_word_o[3]);

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_i[2] && !evt_i[1]) |=> !flag_word_o[2]);

    assert_int_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_word_o[0] && !clr_i[0]) |=> !pulse_o[0]);

    assert_int_flag_R9: assert property (@(posedge clk) disable iff (rst)
        pulse_o[0] |-> flag_word_o[0]);

    assert_shrink_R10: assert property (@(posedge clk) disable iff (rst)
        (prd_a != '0 && cnt_a > prd_a) |=> (cnt_a == '0));
endmodule

bind evtrig_prescale evtrig_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .prd_i       (prd_i),
    .clr_i       (clr_i),
    .pulse_o     (pulse_o),
    .flag_word_o (flag_word_o),
    .cnt_o       (cnt_o)
);

// File: tb/tb_evtrig_prescale.sv
`timescale 1ns/1ps
module tb_evtrig_prescale;
    localparam int W = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    evt_i;
    logic [3*W-1:0] prd_i;
    logic [15:0]   clr_i;
    logic [2:0]    pulse_o;
    logic [15:0]   flag_word_o;
    logic [3*W-1:0] cnt_o;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    // expected state
    int  e_cnt[3];
    bit  e_flag[3];
    bit  e_pulse[3];
    bit  e_pend;

    always #2 clk = ~clk;

    evtrig_prescale #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .prd_i(prd_i), .clr_i(clr_i),
        .pulse_o(pulse_o), .flag_word_o(flag_word_o), .cnt_o(cnt_o)
    );

    function automatic int fpos(int ch);
        return (ch == 0) ? 0 : (ch == 1) ? 2 : 3;
    endfunction

    function automatic logic [15:0] exp_word();
        logic [15:0] w = '0;
        for (int c = 0; c < 3; c++) w[fpos(c)] = e_flag[c];
        return w;
    endfunction

    function automatic logic [11:0] exp_cnt();
        logic [11:0] v = '0;
        for (int c = 0; c < 3; c++) v[c*4 +: 4] = 4'(e_cnt[c]);
        return v;
    endfunction

    function automatic logic [2:0] exp_pulse();
        return {e_pulse[2], e_pulse[1], e_pulse[0]};
    endfunction

    // advance the expected state by one clock using requirement rules
    task automatic model_step();
        for (int c = 0; c < 3; c++) begin
            int  p = int'(prd_i[c*4 +: 4]);
            bit  hit = 0;
            bit  clr = clr_i[fpos(c)];
            if (p == 0 || e_cnt[c] > p) e_cnt[c] = 0;                 // R3, R10
            else if (evt_i[c]) begin
                if (e_cnt[c] + 1 == p) begin hit = 1; e_cnt[c] = 0; end // R4
                else e_cnt[c] = e_cnt[c] + 1;                          // R2
            end
            if (c != 0) begin
                e_pulse[c] = hit;                                      // R5
                e_flag[c]  = (e_flag[c] && !clr) || hit;               // R7
            end else begin
                bit held = e_flag[0] && !clr;                          // R8
                bit go   = !held && (e_pend || hit);                   // R9
                e_pulse[0] = go;
                e_flag[0]  = held || go;
                if (go) e_pend = e_pend && hit;
                else    e_pend = e_pend || hit;
            end
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock: inputs already driven; compare all outputs to model
    task automatic cyc(string tag);
        model_step();
        @(posedge clk); #1;
        check(tag, 32'(pulse_o), 32'(exp_pulse()), "pulse");
        check(tag, 32'(flag_word_o), 32'(exp_word()), "flags");
        check(tag, 32'(cnt_o), 32'(exp_cnt()), "counts");
        @(negedge clk);
        evt_i = '0; clr_i = '0;
    endtask

    task automatic set_prd(int pi, int pa, int pb);
        prd_i = {4'(pb), 4'(pa), 4'(pi)};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; evt_i = '0; clr_i = '0; prd_i = '0;
        for (int c = 0; c < 3; c++) begin
            e_cnt[c] = 0; e_flag[c] = 0; e_pulse[c] = 0;
        end
        e_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        check("R1", 32'(pulse_o), 0, "pulse after reset");
        check("R1", 32'(flag_word_o), 0, "flags after reset");
        check("R1", 32'(cnt_o), 0, "counts after reset");

        // R2/R4/R5/R6: conversion A period 3
        set_prd(0, 3, 0);
        evt_i = 3'b010; cyc("R2");
        evt_i = 3'b010; cyc("R2");
        check("R2", 32'(cnt_o[7:4]), 2, "count after two events");
        evt_i = 3'b010; cyc("R4");
        check("R4", 32'(pulse_o), 3'b010, "pulse on third event");
        check("R4", 32'(cnt_o[7:4]), 0, "count back to zero");
        check("R6", 32'(flag_word_o), 16'h0004, "flag word layout A");
        cyc("R4");
        check("R4", 32'(pulse_o), 0, "pulse lasts one cycle");
        for (int k = 0; k < 3; k++) begin evt_i = 3'b010; cyc("R5"); end
        check("R5", 32'(pulse_o[1]), 1, "pulse while flag set");

        // R7: clear, unused bit ignored, set wins
        clr_i = 16'hFFF2; cyc("R7");
        check("R7", 32'(flag_word_o), 16'h0004, "unused clear bits ignored");
        clr_i = 16'h0004; cyc("R7");
        check("R7", 32'(flag_word_o), 0, "A flag cleared");
        set_prd(0, 1, 1);
        evt_i = 3'b100; cyc("R7");
        evt_i = 3'b100; clr_i = 16'h0008; cyc("R7");
        check("R7", 32'(flag_word_o[3]), 1, "set wins over clear");

        // R8/R9: interrupt gating and pending
        set_prd(1, 0, 0);
        evt_i = 3'b001; cyc("R8");
        check("R8", 32'(pulse_o[0]), 1, "first interrupt");
        evt_i = 3'b001; cyc("R8");
        check("R8", 32'(pulse_o[0]), 0, "blocked while flag set");
        evt_i = 3'b001; cyc("R8");
        cyc("R8");
        check("R8", 32'(pulse_o[0]), 0, "still blocked");
        clr_i = 16'h0001; cyc("R9");
        check("R9", 32'(pulse_o[0]), 1, "pending sent after clear");
        check("R9", 32'(flag_word_o[0]), 1, "flag set again");
        clr_i = 16'h0001; cyc("R8");
        check("R8", 32'(pulse_o[0]), 0, "extra match dropped");
        check("R8", 32'(flag_word_o[0]), 0, "flag clear");

        // R3: disabled channel
        set_prd(0, 0, 0);
        for (int k = 0; k < 5; k++) begin evt_i = 3'b111; cyc("R3"); end
        check("R3", 32'(cnt_o), 0, "disabled counts stay zero");
        check("R3", 32'(pulse_o), 0, "disabled no pulse");

        // R10: shrink period below count
        set_prd(0, 0, 8);
        for (int k = 0; k < 5; k++) begin evt_i = 3'b100; cyc("R10"); end
        check("R10", 32'(cnt_o[11:8]), 5, "count before shrink");
        set_prd(0, 0, 2); evt_i = 3'b100; cyc("R10");
        check("R10", 32'(cnt_o[11:8]), 0, "count reset on shrink");

        // constrained random, fixed seed
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 40) == 0)
                set_prd($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15));
            evt_i = 3'($urandom);
            if ($urandom_range(0, 5) == 0) clr_i = 16'($urandom);
            cyc("R2/R4/R8 random");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule